// File: doc/BRIEF.md
# Periodic Tick Timer with Wait Channels

The block derives a slow system tick from a machine-cycle enable. A reloadable up-counter advances once per enabled clock. When it passes its all-ones value it reloads and emits a one-cycle tick strobe. The reload value is computed from the wanted tick period, minus a fixed latency offset. With the defaults of a 16-bit counter, a 10000-cycle period and an offset of 7, the reload value is 0xD8F7. The reload takes effect in the same cycle as the overflow, so each tick period is the wanted period shortened by the offset.

An 8-bit tick count advances on every tick and wraps freely. Several wait channels share this count. Arming a channel with an interval stores a deadline equal to the count plus the interval, modulo 256. A channel fires a one-cycle event on the tick at which the count equals its deadline, then moves the deadline on by the same interval. A pulse generator waits for the next tick boundary and then holds its output high for a programmed number of tick periods.

The machine-cycle enable is normally high one clock in twelve. It is supplied from outside.

Top module: `tick_timer`

## Requirements
- R1: While rst_ni is low and in the first cycle after reset, tick_o, evt_o and pulse_o are 0 and tick_cnt_o is 0. Reset disarms every channel and loads the counter with the reload value.
- R2: The counter changes only on clocks where mc_en_i is 1. With mc_en_i held at 0, no tick occurs and tick_cnt_o holds its value.
- R3: tick_o is high for exactly one cycle, once every 2^CNT_W − RELOAD enabled clocks, where RELOAD = 2^CNT_W − PERIOD + COMP (0xD8F7 by default). The first tick follows the same number of enabled clocks after reset.
- R4: tick_cnt_o rises by one, modulo 256, in the cycle where tick_o is high, and is stable in every other cycle.
- R5: A one-cycle pulse on arm_i[c] stores deadline = (tick count after that edge) + interval_i[c] mod 256. evt_o[c] goes high in the cycle where tick_o is high and tick_cnt_o equals the deadline.
- R6: After each event the channel adds its stored interval to the deadline. It therefore fires again after the same number of ticks without being re-armed.
- R7: An interval of 0 produces an event every 256 ticks.
- R8: Each channel keeps its own deadline and interval. Arming or firing one channel has no effect on the others.
- R9: An event lasts one cycle and occurs only in a cycle where tick_o is high.
- R10: A trigger pulse captures pulse_len_i. pulse_o rises in the cycle of the next tick, stays high for that many tick periods, and falls in a tick cycle. A length of 0 means 256 periods.
- R11: A trigger received while a pulse is pending or in progress is ignored, and the running pulse keeps its original length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mc_en_i | input | 1 | Machine-cycle enable; the counter advances when high |
| arm_i | input | NCH | Per-channel arm strobe |
| interval_i | input | NCH*TCW | Per-channel interval in ticks; channel c uses bits [c*TCW +: TCW] |
| trig_i | input | 1 | Pulse start strobe |
| pulse_len_i | input | TCW | Pulse length in ticks, sampled on trig_i |
| tick_o | output | 1 | One-cycle tick strobe |
| tick_cnt_o | output | TCW | Free-running tick count |
| evt_o | output | NCH | Per-channel one-cycle event |
| pulse_o | output | 1 | Pulse output |

## Verification
The bench builds the block with an 8-bit counter, a period of 20 and an offset of 3. This gives a reload value of 239 and a tick every 17 enabled clocks. With ticks that short, the 256-tick wrap of the count and the 0-means-256 cases for both channel intervals and pulse length complete within a few thousand clocks. Three channels with the default 8-bit interval width are enough to check deadline independence. They also cover a channel firing on every tick.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  typedef enum logic [1:0] {
    PS_IDLE = 2'd0,
    PS_WAIT = 2'd1,
    PS_HIGH = 2'd2
  } pulse_st_e;
endpackage

// File: rtl/tick_base.sv
module tick_base #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned RELOAD = 55543
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mc_en_i,
  output logic wrap_o
);
  localparam logic [CNT_W-1:0] RLD  = CNT_W'(RELOAD);
  localparam logic [CNT_W-1:0] ALL1 = {CNT_W{1'b1}};

  logic [CNT_W-1:0] tmr_q;

  assign wrap_o = mc_en_i && (tmr_q == ALL1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       tmr_q <= RLD;
    else if (wrap_o)   tmr_q <= RLD;   // reload in the overflow cycle
    else if (mc_en_i)  tmr_q <= tmr_q + 1'b1;
  end
endmodule

// File: rtl/wait_chan.sv
module wait_chan #(
  parameter int unsigned TCW = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           arm_i,
  input  logic [TCW-1:0] interval_i,
  input  logic           tick_i,
  input  logic [TCW-1:0] cnt_nxt_i,
  output logic           evt_o
);
  logic           act_q;
  logic [TCW-1:0] ivl_q;
  logic [TCW-1:0] tgt_q;
  logic           hit;

  assign hit = act_q && tick_i && (tgt_q == cnt_nxt_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      ivl_q <= '0;
      tgt_q <= '0;
      evt_o <= 1'b0;
    end else if (arm_i) begin
      // interval 0 wraps back to the same count: 256 ticks
      act_q <= 1'b1;
      ivl_q <= interval_i;
      tgt_q <= cnt_nxt_i + interval_i;
      evt_o <= 1'b0;
    end else begin
      evt_o <= hit;
      if (hit) tgt_q <= tgt_q + ivl_q;
    end
  end
endmodule

// File: rtl/pulse_gen.sv
module pulse_gen
  import tick_timer_pkg::*;
#(
  parameter int unsigned TCW = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           trig_i,
  input  logic [TCW-1:0] len_i,
  input  logic           tick_i,
  output logic           pulse_o
);
  pulse_st_e      st_q;
  logic [TCW-1:0] len_q;
  logic [TCW-1:0] rem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= PS_IDLE;
      len_q   <= '0;
      rem_q   <= '0;
      pulse_o <= 1'b0;
    end else begin
      unique case (st_q)
        PS_IDLE: if (trig_i) begin
          st_q  <= PS_WAIT;
          len_q <= len_i;
        end
        PS_WAIT: if (tick_i) begin
          st_q    <= PS_HIGH;
          rem_q   <= len_q;
          pulse_o <= 1'b1;
        end
        PS_HIGH: if (tick_i) begin
          // rem 0 counts down through 255, giving 256 periods
          if (rem_q == TCW'(1)) begin
            st_q    <= PS_IDLE;
            pulse_o <= 1'b0;
          end else begin
            rem_q <= rem_q - 1'b1;
          end
        end
        default: st_q <= PS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tick_timer.sv
module tick_timer #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned PERIOD = 10000,
  parameter int unsigned COMP   = 7,
  parameter int unsigned NCH    = 4,
  parameter int unsigned TCW    = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               mc_en_i,
  input  logic [NCH-1:0]     arm_i,
  input  logic [NCH*TCW-1:0] interval_i,
  input  logic               trig_i,
  input  logic [TCW-1:0]     pulse_len_i,
  output logic               tick_o,
  output logic [TCW-1:0]     tick_cnt_o,
  output logic [NCH-1:0]     evt_o,
  output logic               pulse_o
);
  localparam int unsigned RELOAD = (2 ** CNT_W) - PERIOD + COMP;

  logic           tick_now;
  logic [TCW-1:0] cnt_q;
  logic [TCW-1:0] cnt_nxt;

  tick_base #(.CNT_W(CNT_W), .RELOAD(RELOAD)) u_base (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .mc_en_i (mc_en_i),
    .wrap_o  (tick_now)
  );

  assign cnt_nxt = cnt_q + {{(TCW-1){1'b0}}, tick_now};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else begin
      cnt_q  <= cnt_nxt;
      tick_o <= tick_now;
    end
  end

  assign tick_cnt_o = cnt_q;

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    wait_chan #(.TCW(TCW)) u_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .arm_i      (arm_i[c]),
      .interval_i (interval_i[c*TCW +: TCW]),
      .tick_i     (tick_now),
      .cnt_nxt_i  (cnt_nxt),
      .evt_o      (evt_o[c])
    );
  end

  pulse_gen #(.TCW(TCW)) u_pulse (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .trig_i  (trig_i),
    .len_i   (pulse_len_i),
    .tick_i  (tick_now),
    .pulse_o (pulse_o)
  );
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
  parameter int unsigned NCH = 4,
  parameter int unsigned TCW = 8
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           mc_en_i,
  input logic           tick_o,
  input logic [TCW-1:0] tick_cnt_o,
  input logic [NCH-1:0] evt_o,
  input logic           pulse_o
);
  a_r1_reset_quiet: assert property (@(posedge clk_i)
    !rst_ni |=> (!rst_ni |-> (!tick_o && evt_o == '0 && !pulse_o && tick_cnt_o == '0)));

  a_r2_no_tick_without_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mc_en_i |=> !tick_o);

  a_r3_tick_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);

  a_r4_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> tick_cnt_o == $past(tick_cnt_o) + 1'b1);

  a_r4_count_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_o |-> $stable(tick_cnt_o));

  a_r9_evt_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_o != '0) |-> tick_o);

  a_r9_evt_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_o != '0) |=> (evt_o == '0));

  a_r10_pulse_rise_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pulse_o) |-> tick_o);

  a_r10_pulse_fall_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pulse_o) |-> tick_o);
endmodule

bind tick_timer tick_timer_chk #(.NCH(NCH), .TCW(TCW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mc_en_i    (mc_en_i),
  .tick_o     (tick_o),
  .tick_cnt_o (tick_cnt_o),
  .evt_o      (evt_o),
  .pulse_o    (pulse_o)
);

// File: tb/sim_tick_timer.sv
module sim_tick_timer;
  localparam int NCH = 3;
  localparam int TCW = 8;
  localparam int TP  = 17;  // 2^8 - (256 - 20 + 3)

  // {channel, interval, expected ticks to first event}
  localparam int NV = 5;
  localparam int VEC [NV][3] = '{
    '{0, 3, 3}, '{1, 5, 5}, '{2, 1, 1}, '{0, 2, 2}, '{1, 0, 256}
  };

  logic               clk = 1'b0;
  logic               rst_ni = 1'b0;
  logic               mc_en_i = 1'b1;
  logic [NCH-1:0]     arm_i = '0;
  logic [NCH*TCW-1:0] interval_i = '0;
  logic               trig_i = 1'b0;
  logic [TCW-1:0]     pulse_len_i = '0;
  logic               tick_o;
  logic [TCW-1:0]     tick_cnt_o;
  logic [NCH-1:0]     evt_o;
  logic               pulse_o;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #2 clk = ~clk;

  tick_timer #(.CNT_W(8), .PERIOD(20), .COMP(3), .NCH(NCH), .TCW(TCW)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .mc_en_i(mc_en_i), .arm_i(arm_i),
    .interval_i(interval_i), .trig_i(trig_i), .pulse_len_i(pulse_len_i),
    .tick_o(tick_o), .tick_cnt_o(tick_cnt_o), .evt_o(evt_o), .pulse_o(pulse_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_tick();
    do @(negedge clk); while (!tick_o);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int n, k, base, c0, hi;
    int e0, e1, e2;
    repeat (3) @(negedge clk);
    chk(!tick_o && evt_o == '0 && !pulse_o && tick_cnt_o == 0, "R1 reset outputs",
        int'(tick_cnt_o), 0);
    rst_ni = 1'b1;

    // R3: first tick and period
    n = 0;
    do begin @(negedge clk); n++; end while (!tick_o);
    chk(n == TP, "R3 first tick delay", n, TP);
    chk(tick_cnt_o == 1, "R4 count after first tick", int'(tick_cnt_o), 1);
    n = 0;
    do begin @(negedge clk); n++; end while (!tick_o);
    chk(n == TP, "R3 tick period", n, TP);
    chk(tick_cnt_o == 2, "R4 count increments", int'(tick_cnt_o), 2);

    // R2: enable low freezes the counter
    mc_en_i = 1'b0;
    base = int'(tick_cnt_o);
    k = 0;
    repeat (50) begin @(negedge clk); if (tick_o) k++; end
    chk(k == 0, "R2 no tick with enable low", k, 0);
    chk(tick_cnt_o == base, "R2 count held", int'(tick_cnt_o), base);
    mc_en_i = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (!tick_o);
    chk(n == TP, "R2 full period after re-enable", n, TP);

    // R5, R6, R7: table of channel cases
    for (int v = 0; v < NV; v++) begin
      int ch, ivl, exp;
      ch = VEC[v][0]; ivl = VEC[v][1]; exp = VEC[v][2];
      wait_tick();
      base = int'(tick_cnt_o);
      interval_i[ch*TCW +: TCW] = TCW'(ivl);
      arm_i[ch] = 1'b1;
      @(negedge clk);
      arm_i[ch] = 1'b0;
      k = 0;
      forever begin
        if (tick_o) k++;
        if (evt_o[ch]) break;
        @(negedge clk);
      end
      chk(k == exp, "R5 ticks to first event", k, exp);
      chk(int'(tick_cnt_o) == ((base + exp) % 256), "R5 count at event",
          int'(tick_cnt_o), (base + exp) % 256);
      chk(tick_o, "R9 event with tick", int'(tick_o), 1);
      @(negedge clk);
      chk(!evt_o[ch], "R9 event one cycle", int'(evt_o[ch]), 0);
      k = 0;
      forever begin
        if (tick_o) k++;
        if (evt_o[ch]) break;
        @(negedge clk);
      end
      chk(k == exp, (ivl == 0) ? "R7 interval 0 repeat" : "R6 rearm period", k, exp);
    end

    // R8: independent channels (ch2 still armed with interval 1)
    wait_tick();
    interval_i[0 +: TCW] = 8'd4;
    interval_i[TCW +: TCW] = 8'd6;
    arm_i = 3'b011;
    @(negedge clk);
    arm_i = '0;
    e0 = 0; e1 = 0; e2 = 0; k = 0;
    while (k < 12) begin
      @(negedge clk);
      if (tick_o) k++;
      if (evt_o[0]) e0++;
      if (evt_o[1]) e1++;
      if (evt_o[2]) e2++;
    end
    chk(e0 == 3, "R8 ch0 events", e0, 3);
    chk(e1 == 2, "R8 ch1 events", e1, 2);
    chk(e2 == 12, "R8 ch2 untouched", e2, 12);

    // R10, R11: pulse length 4
    wait_tick();
    repeat (5) @(negedge clk);
    pulse_len_i = 8'd4;
    trig_i = 1'b1;
    @(negedge clk);
    trig_i = 1'b0;
    pulse_len_i = 8'd9;
    n = 1;
    while (!pulse_o) begin
      chk(!tick_o, "R10 pulse waits for tick", int'(tick_o), 0);
      @(negedge clk); n++;
    end
    chk(tick_o, "R10 rise on tick", int'(tick_o), 1);
    c0 = int'(tick_cnt_o);
    trig_i = 1'b1;  // R11: ignored while busy
    @(negedge clk);
    trig_i = 1'b0;
    hi = 1;
    while (pulse_o) begin @(negedge clk); hi++; end
    chk(hi == 4 * TP, "R11 retrigger ignored, width", hi, 4 * TP);
    chk(tick_o, "R10 fall on tick", int'(tick_o), 1);
    chk(int'(tick_cnt_o) == ((c0 + 4) % 256), "R10 count at fall",
        int'(tick_cnt_o), (c0 + 4) % 256);
    repeat (40) @(negedge clk);
    chk(!pulse_o, "R11 no pulse from busy trigger", int'(pulse_o), 0);

    // R10: length 0 means 256
    pulse_len_i = 8'd0;
    trig_i = 1'b1;
    @(negedge clk);
    trig_i = 1'b0;
    while (!pulse_o) @(negedge clk);
    hi = 0;
    while (pulse_o) begin @(negedge clk); hi++; end
    chk(hi == 256 * TP, "R10 length 0 width", hi, 256 * TP);

    // R1: asynchronous reset mid-run
    @(negedge clk);
    rst_ni = 1'b0;
    #1;
    chk(!tick_o && evt_o == '0 && !pulse_o && tick_cnt_o == 0, "R1 async reset",
        int'(tick_cnt_o), 0);
    @(negedge clk);
    rst_ni = 1'b1;
    k = 0;
    repeat (300) begin @(negedge clk); if (evt_o != '0) k++; end
    chk(k == 0, "R1 channels disarmed", k, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule